// File: doc/BRIEF.md
# FDL Event Monitor

This block sits behind a T1 framer on the receive side of the facility data link. It takes the link one bit at a time, strobed by a valid input, and groups every eight accepted bits into a receive byte. Each finished byte is compared against two host-programmed match bytes. A running count of consecutive ones flags abort sequences. A sixteen-bit sliding window finds bit-oriented code (BOC) codewords, confirms a code when it repeats, and later declares the code gone once enough abort-free bits have passed. A pulse from the transmit serializer reports that its buffer ran dry.

All of these events are caught in a sticky status register. A mask register selects which of them drive a single active-high interrupt. The host reaches status, mask, the match bytes and the receive buffer through a small address/strobe register port. Read data is combinational from the addressed register. After an interrupt for a new BOC, the host finds the six-bit code in the receive buffer.

Top module: `fdl_event_monitor`

## Requirements
- R1: Bits are shifted in first-received-first into the byte. The 8th, 16th, 24th, ... bit accepted since reset completes a byte, which is loaded into the receive buffer (address 4) and sets status bit 3 (buffer full). R5 gives the exception.
- R2: When a completed byte equals match register A (address 2) or match register B (address 3), status bit 3 and status bit 1 (match) are both set.
- R3: Status bit 4 (abort) is set by the bit that brings a run of consecutive ones to exactly eight. Further ones in the same run do not set it again; a zero restarts the run.
- R4: A codeword is present when the last 16 bits, oldest first, read 11111111, 0, c5..c0, 0. A code is valid when two consecutive codewords carry the same c5..c0. A valid code sets status bit 0 (BOC change) if no BOC is active or the code differs from the active one, and loads {00,c5..c0} into the receive buffer. A repeat of the active code sets nothing.
- R5: While a BOC is active, and on the bit that makes one active, byte completions neither load the receive buffer nor set bits 3 or 1.
- R6: While a BOC is active, the 30th consecutive bit without an abort sets status bit 5 (BOC clear) and ends the BOC. Counting restarts at onset and at every abort. Only one clear event occurs per episode, and a new episode again needs two matching codewords.
- R7: A one-cycle pulse on the transmit-empty input sets status bit 2.
- R8: Status bits are sticky and clear on the clock edge of a status read (address 0). An event in that same cycle stays set. Writes to the status address have no effect.
- R9: The mask register (address 1) stores bits 5:0. Bits 7:6 of status and mask read as 0. Status, mask, match registers and the receive buffer reset to 0.
- R10: The interrupt output is high exactly when some status bit is set together with its mask bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fdlBit | input | 1 | Received data link bit |
| fdlValid | input | 1 | Qualifies fdlBit for one cycle |
| txEmpty | input | 1 | Pulse from transmit path: buffer emptied |
| regAddr | input | ADDR_W | Register address |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (clears status when addressed) |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data of the addressed register |
| irq | output | 1 | Active-high interrupt |

## Verification
The bench builds the block with its defaults: an eight-ones abort run, a 30-bit clear window, two match slots and a three-bit address. With these values the clear boundary can be hit exactly, at 29 and then 30 quiet bits, and a random stream of codewords, idle flags and noise goes through many complete BOC episodes within a short run. Byte alignment drifts freely against codeword boundaries, so bytes and codes complete on the same bit often enough to exercise the gating in R5.

// File: rtl/fdl_mon_pkg.sv
package fdl_mon_pkg;
  localparam int DATA_W     = 8;
  localparam int CODE_W     = DATA_W - 2;
  localparam int WIN_W      = 2 * DATA_W;
  localparam int NUM_MATCH  = 2;

  // status / mask bit positions
  localparam int ST_COS     = 0;
  localparam int ST_MATCH   = 1;
  localparam int ST_TXEMPTY = 2;
  localparam int ST_FULL    = 3;
  localparam int ST_ABORT   = 4;
  localparam int ST_CLEAR   = 5;
  localparam int ST_USED    = 6;

  // register map
  localparam int ADR_STATUS = 0;
  localparam int ADR_MASK   = 1;
  localparam int ADR_MATCH0 = 2;
  localparam int ADR_RXBUF  = ADR_MATCH0 + NUM_MATCH;

  typedef struct packed {
    logic              loadByte;
    logic              loadBoc;
    logic              evAbort;
    logic              evClear;
    logic              evCos;
    logic [CODE_W-1:0] code;
  } ctl_strobe_t;
endpackage

// File: rtl/fdl_mon_ctrl.sv
module fdl_mon_ctrl
  import fdl_mon_pkg::*;
#(
  parameter int ABORT_ONES = 8,
  parameter int CLEAR_BITS = 30
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitValid,
  input  logic [WIN_W-1:0] winNext,
  output ctl_strobe_t      strobe
);
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int ONES_W = $clog2(ABORT_ONES + 1);
  localparam int CNT_W  = $clog2(CLEAR_BITS + 1);

  logic [IDX_W-1:0]  bitIdx;
  logic [ONES_W-1:0] onesRun;
  logic [CNT_W-1:0]  clrCnt;
  logic              haveLast;
  logic [CODE_W-1:0] lastCode;
  logic              bocActive;
  logic [CODE_W-1:0] activeCode;

  logic              newBit;
  logic              byteDone;
  logic              abortNow;
  logic              codeHit;
  logic [CODE_W-1:0] code;
  logic              onset;
  logic              clearNow;

  always_comb begin
    newBit   = winNext[0];
    byteDone = bitValid && (bitIdx == IDX_W'(DATA_W - 1));
    abortNow = bitValid && newBit && (onesRun == ONES_W'(ABORT_ONES - 1));
    codeHit  = bitValid && (&winNext[WIN_W-1:DATA_W]) &&
               !winNext[DATA_W-1] && !winNext[0];
    code     = winNext[DATA_W-2:1];
    onset    = codeHit && haveLast && (code == lastCode) &&
               (!bocActive || (code != activeCode));
    clearNow = bitValid && bocActive && !onset && !abortNow &&
               (clrCnt == CNT_W'(CLEAR_BITS - 1));
  end

  always_comb begin
    strobe.loadByte = byteDone && !bocActive && !onset;
    strobe.loadBoc  = onset;
    strobe.evAbort  = abortNow;
    strobe.evClear  = clearNow;
    strobe.evCos    = onset;
    strobe.code     = code;
  end

  // bit position within the byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitIdx <= '0;
    end else if (bitValid) begin
      bitIdx <= byteDone ? '0 : bitIdx + 1'b1;
    end
  end

  // run of consecutive ones, saturating at the abort length
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onesRun <= '0;
    end else if (bitValid) begin
      if (!newBit)                               onesRun <= '0;
      else if (onesRun != ONES_W'(ABORT_ONES))   onesRun <= onesRun + 1'b1;
    end
  end

  // codeword history, BOC episode and clear window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haveLast   <= 1'b0;
      lastCode   <= '0;
      bocActive  <= 1'b0;
      activeCode <= '0;
      clrCnt     <= '0;
    end else begin
      if (codeHit) begin
        lastCode <= code;
        haveLast <= 1'b1;
      end
      if (onset) begin
        bocActive  <= 1'b1;
        activeCode <= code;
        clrCnt     <= '0;
      end else if (bocActive && bitValid) begin
        if (abortNow) begin
          clrCnt <= '0;
        end else if (clearNow) begin
          bocActive <= 1'b0;
          haveLast  <= 1'b0;
          clrCnt    <= '0;
        end else begin
          clrCnt <= clrCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fdl_mon_datapath.sv
module fdl_mon_datapath
  import fdl_mon_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bitValid,
  input  logic               bitIn,
  input  logic               txEmpty,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWr,
  input  logic               regRd,
  input  logic [DATA_W-1:0]  regWdata,
  input  ctl_strobe_t        strobe,
  output logic [WIN_W-1:0]   winNext,
  output logic [DATA_W-1:0]  regRdata,
  output logic [ST_USED-1:0] statusVec,
  output logic               irq
);
  logic [WIN_W-1:0]   win;
  logic [DATA_W-1:0]  rxBuf;
  logic [DATA_W-1:0]  matchReg [NUM_MATCH];
  logic [ST_USED-1:0] maskQ;
  logic [ST_USED-1:0] statusQ;
  logic [ST_USED-1:0] evVec;
  logic [DATA_W-1:0]  newByte;
  logic               matchHit;
  logic               rdStatus;

  assign winNext = {win[WIN_W-2:0], bitIn};
  assign newByte = winNext[DATA_W-1:0];

  always_comb begin
    matchHit = 1'b0;
    for (int i = 0; i < NUM_MATCH; i++) begin
      if (newByte == matchReg[i]) matchHit = 1'b1;
    end
  end

  always_comb begin
    evVec              = '0;
    evVec[ST_COS]      = strobe.evCos;
    evVec[ST_MATCH]    = strobe.loadByte && matchHit;
    evVec[ST_TXEMPTY]  = txEmpty;
    evVec[ST_FULL]     = strobe.loadByte;
    evVec[ST_ABORT]    = strobe.evAbort;
    evVec[ST_CLEAR]    = strobe.evClear;
    rdStatus           = regRd && (regAddr == ADDR_W'(ADR_STATUS));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      win     <= '0;
      rxBuf   <= '0;
      statusQ <= '0;
    end else begin
      if (bitValid) win <= winNext;
      if (strobe.loadBoc)       rxBuf <= DATA_W'(strobe.code);
      else if (strobe.loadByte) rxBuf <= newByte;
      statusQ <= (rdStatus ? '0 : statusQ) | evVec;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
      for (int i = 0; i < NUM_MATCH; i++) matchReg[i] <= '0;
    end else if (regWr) begin
      if (regAddr == ADDR_W'(ADR_MASK)) maskQ <= regWdata[ST_USED-1:0];
      for (int i = 0; i < NUM_MATCH; i++) begin
        if (regAddr == ADDR_W'(ADR_MATCH0 + i)) matchReg[i] <= regWdata;
      end
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_W'(ADR_STATUS)) regRdata[ST_USED-1:0] = statusQ;
    if (regAddr == ADDR_W'(ADR_MASK))   regRdata[ST_USED-1:0] = maskQ;
    if (regAddr == ADDR_W'(ADR_RXBUF))  regRdata = rxBuf;
    for (int i = 0; i < NUM_MATCH; i++) begin
      if (regAddr == ADDR_W'(ADR_MATCH0 + i)) regRdata = matchReg[i];
    end
  end

  assign statusVec = statusQ;
  assign irq       = |(statusQ & maskQ);
endmodule

// File: rtl/fdl_event_monitor.sv
module fdl_event_monitor
  import fdl_mon_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int ABORT_ONES = 8,
  parameter int CLEAR_BITS = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fdlBit,
  input  logic              fdlValid,
  input  logic              txEmpty,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  output logic              irq
);
  ctl_strobe_t        ctlStrobe;
  logic [WIN_W-1:0]   winNext;
  logic [ST_USED-1:0] statusVec;

  fdl_mon_ctrl #(
    .ABORT_ONES(ABORT_ONES),
    .CLEAR_BITS(CLEAR_BITS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bitValid (fdlValid),
    .winNext  (winNext),
    .strobe   (ctlStrobe)
  );

  fdl_mon_datapath #(
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .bitValid  (fdlValid),
    .bitIn     (fdlBit),
    .txEmpty   (txEmpty),
    .regAddr   (regAddr),
    .regWr     (regWr),
    .regRd     (regRd),
    .regWdata  (regWdata),
    .strobe    (ctlStrobe),
    .winNext   (winNext),
    .regRdata  (regRdata),
    .statusVec (statusVec),
    .irq       (irq)
  );
endmodule

// File: rtl/fdl_event_monitor_checker.sv
module fdl_event_monitor_checker
  import fdl_mon_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               fdlBit,
  input logic               fdlValid,
  input logic               txEmpty,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               regWr,
  input logic               regRd,
  input logic [7:0]         regRdata,
  input logic               irq,
  input logic               loadByte,
  input logic               evAbort,
  input logic               evCos,
  input logic               evClear,
  input logic [ST_USED-1:0] statusVec
);
  p_full_latch_r1: assert property (@(posedge clk) disable iff (!rstN)
    loadByte |=> statusVec[ST_FULL]);

  p_abort_on_one_r3: assert property (@(posedge clk) disable iff (!rstN)
    evAbort |-> (fdlValid && fdlBit));

  p_cos_on_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    evCos |-> (fdlValid && !fdlBit));

  p_clear_on_bit_r6: assert property (@(posedge clk) disable iff (!rstN)
    evClear |-> (fdlValid && !evAbort && !evCos));

  p_tx_latch_r7: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |=> statusVec[ST_TXEMPTY]);

  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == ADDR_W'(ADR_STATUS) && !fdlValid && !txEmpty)
      |=> (statusVec == '0));

  p_mask_upper_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(ADR_MASK) || regAddr == ADDR_W'(ADR_STATUS))
      |-> (regRdata[7:ST_USED] == '0));

  p_irq_fall_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(regRd || regWr));
endmodule

bind fdl_event_monitor fdl_event_monitor_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .fdlBit    (fdlBit),
  .fdlValid  (fdlValid),
  .txEmpty   (txEmpty),
  .regAddr   (regAddr),
  .regWr     (regWr),
  .regRd     (regRd),
  .regRdata  (regRdata),
  .irq       (irq),
  .loadByte  (ctlStrobe.loadByte),
  .evAbort   (ctlStrobe.evAbort),
  .evCos     (ctlStrobe.evCos),
  .evClear   (ctlStrobe.evClear),
  .statusVec (statusVec)
);

// File: tb/tb_fdl_event_monitor.sv
module tb_fdl_event_monitor;
  logic       clk = 1'b0;
  logic       rstN;
  logic       fdlBit, fdlValid, txEmpty, regWr, regRd;
  logic [2:0] regAddr;
  logic [7:0] regWdata, regRdata;
  logic       irq;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  // reference model state
  logic [15:0] mWin;
  int          mIdx, mOnes, mCnt;
  logic        mHave, mActive;
  logic [5:0]  mLast, mCode;
  logic [7:0]  mStatus, mMask, mMatchA, mMatchB, mRx;

  always #2 clk = ~clk;

  fdl_event_monitor dut (
    .clk(clk), .rstN(rstN), .fdlBit(fdlBit), .fdlValid(fdlValid),
    .txEmpty(txEmpty), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic modelBit(input logic b);
    logic [15:0] w;
    logic abortEv, hit, onset, clr;
    logic [5:0] c;
    w = {mWin[14:0], b};
    abortEv = b && (mOnes == 7);
    if (b) begin
      if (mOnes != 8) mOnes++;
    end else mOnes = 0;
    hit   = (w[15:8] == 8'hFF) && !w[7] && !w[0];
    c     = w[6:1];
    onset = hit && mHave && (c == mLast) && (!mActive || c != mCode);
    clr   = mActive && !onset && !abortEv && (mCnt == 29);
    if (mIdx == 7 && !mActive && !onset) begin
      mRx = w[7:0];
      mStatus |= 8'h08;
      if (w[7:0] == mMatchA || w[7:0] == mMatchB) mStatus |= 8'h02;
    end
    if (abortEv) mStatus |= 8'h10;
    if (hit) begin mLast = c; mHave = 1'b1; end
    if (onset) begin
      mStatus |= 8'h01; mRx = {2'b00, c}; mActive = 1'b1; mCode = c; mCnt = 0;
    end else if (mActive) begin
      if (abortEv) mCnt = 0;
      else if (clr) begin
        mStatus |= 8'h20; mActive = 1'b0; mHave = 1'b0; mCnt = 0;
      end else mCnt++;
    end
    mIdx = (mIdx + 1) % 8;
    mWin = w;
  endtask

  function automatic logic [7:0] expOf(input logic [2:0] a);
    case (a)
      3'd0: return mStatus;
      3'd1: return mMask;
      3'd2: return mMatchA;
      3'd3: return mMatchB;
      3'd4: return mRx;
      default: return 8'h00;
    endcase
  endfunction

  task automatic sendBit(input logic b);
    @(negedge clk);
    fdlValid = 1'b1; fdlBit = b;
    modelBit(b);
    @(negedge clk);
    fdlValid = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
  endtask

  task automatic sendCode(input logic [5:0] c);
    sendByte(8'hFF);
    sendBit(1'b0);
    for (int i = 5; i >= 0; i--) sendBit(c[i]);
    sendBit(1'b0);
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    if (a == 3'd1) mMask = d & 8'h3F;
    if (a == 3'd2) mMatchA = d;
    if (a == 3'd3) mMatchB = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1 d = regRdata;
    if (a == 3'd0) mStatus = 8'h00;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic chkRead(input logic [2:0] a, input string tag);
    logic [7:0] e, d;
    e = expOf(a);
    readReg(a, d);
    chk(tag, d, e);
  endtask

  task automatic chkIrq(input string tag);
    #1 chk(tag, {7'b0, irq}, {7'b0, |(mStatus & mMask)});
  endtask

  task automatic txPulse();
    @(negedge clk);
    txEmpty = 1'b1; mStatus |= 8'h04;
    @(negedge clk);
    txEmpty = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: run hung actual=%0d expected<150000 cycles", cyc);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd90210));
    rstN = 1'b0; fdlBit = 0; fdlValid = 0; txEmpty = 0;
    regWr = 0; regRd = 0; regAddr = '0; regWdata = '0;
    mWin = '0; mIdx = 0; mOnes = 0; mCnt = 0; mHave = 0; mActive = 0;
    mLast = '0; mCode = '0; mStatus = '0; mMask = '0; mMatchA = '0;
    mMatchB = '0; mRx = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R9: reset values, R10: interrupt low
    chkRead(3'd0, "R9 status reset");
    chkRead(3'd1, "R9 mask reset");
    chkRead(3'd4, "R9 rxbuf reset");
    chkRead(3'd2, "R9 matchA reset");
    chkIrq("R10 irq reset");

    // R9: mask upper bits
    writeReg(3'd1, 8'hFF);
    readReg(3'd1, d); chk("R9 mask bits 7:6 read 0", d, 8'h3F);

    // R2: match registers
    writeReg(3'd2, 8'h3C);
    writeReg(3'd3, 8'hC3);
    chkRead(3'd2, "R2 matchA readback");
    chkRead(3'd3, "R2 matchB readback");

    // R1: byte assembly
    sendByte(8'hA5);
    readReg(3'd4, d); chk("R1 rxbuf holds byte", d, 8'hA5);
    readReg(3'd0, d); chk("R1 full without match", d, 8'h08);
    sendByte(8'h3C);
    readReg(3'd0, d); chk("R2 match A", d, 8'h0A);
    sendByte(8'hC3);
    readReg(3'd0, d); chk("R2 match B", d, 8'h0A);
    readReg(3'd0, d); chk("R8 read clears status", d, 8'h00);

    // R8: status write ignored
    writeReg(3'd0, 8'hFF);
    readReg(3'd0, d); chk("R8 status write ignored", d, 8'h00);

    // R7 / R10
    txPulse();
    chkIrq("R10 irq with tx event unmasked");
    readReg(3'd0, d); chk("R7 tx empty latched", d, 8'h04);
    writeReg(3'd1, 8'h00);
    txPulse();
    chkIrq("R10 irq masked off");
    writeReg(3'd1, 8'h04);
    chkIrq("R10 irq after unmask");

    // R8: event in same cycle as read stays set
    @(negedge clk);
    regAddr = 3'd0; regRd = 1'b1; txEmpty = 1'b1;
    #1 chk("R8 read data before race edge", regRdata, 8'h04);
    mStatus = 8'h04;
    @(negedge clk);
    regRd = 1'b0; txEmpty = 1'b0;
    readReg(3'd0, d); chk("R8 event during read survives", d, 8'h04);

    // R3: abort on eight ones, no retrigger in same run
    sendByte(8'hFF);
    readReg(3'd0, d); chk("R3 abort set", d & 8'h10, 8'h10);
    sendByte(8'hFF);
    readReg(3'd0, d); chk("R3 no retrigger in run", d & 8'h10, 8'h00);
    sendBit(1'b0);

    // R4: BOC validation
    sendCode(6'h15);
    readReg(3'd0, d); chk("R4 single codeword not valid", d & 8'h01, 8'h00);
    sendCode(6'h15);
    readReg(3'd0, d); chk("R4 BOC change on repeat", d & 8'h01, 8'h01);
    readReg(3'd4, d); chk("R4 code in rxbuf", d, 8'h15);
    sendCode(6'h15);
    readReg(3'd0, d); chk("R4 same code no new event", d & 8'h01, 8'h00);
    sendCode(6'h2A);
    sendCode(6'h2A);
    readReg(3'd0, d); chk("R4 new code change event", d & 8'h01, 8'h01);
    readReg(3'd4, d); chk("R4 new code in rxbuf", d, 8'h2A);

    // R5 / R6: clear window
    for (int i = 0; i < 29; i++) sendBit(1'b0);
    readReg(3'd0, d); chk("R6 no clear at 29 bits", d & 8'h20, 8'h00);
    chk("R5 no full while BOC active", d & 8'h0A, 8'h00);
    readReg(3'd4, d); chk("R5 rxbuf keeps code", d, 8'h2A);
    sendBit(1'b0);
    readReg(3'd0, d); chk("R6 clear at 30th bit", d & 8'h20, 8'h20);
    for (int i = 0; i < 40; i++) sendBit(1'b0);
    readReg(3'd0, d); chk("R6 single clear per episode", d & 8'h20, 8'h00);
    chk("R5 bytes resume after clear", d & 8'h08, 8'h08);

    // random phase against the model (R1-R10)
    writeReg(3'd2, 8'h7E);
    writeReg(3'd3, 8'h5A);
    for (int it = 0; it < 600; it++) begin
      int unsigned r = $urandom % 12;
      if (r < 4)       sendBit(1'($urandom % 2));
      else if (r < 6)  sendCode(($urandom % 2) ? 6'h07 : 6'h31);
      else if (r == 6) sendByte(8'h7E);
      else if (r == 7) txPulse();
      else if (r == 8) writeReg(3'd1, 8'($urandom));
      else if (r == 9) chkRead(3'd0, "R8 random status");
      else if (r == 10) chkRead(3'd4, "R1 random rxbuf");
      else chkIrq("R10 random irq");
    end
    chkRead(3'd0, "R6 final status");

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule